// File: doc/BRIEF.md
# Protection Region Range Decoder

This block turns each protection entry's configuration byte and its word-granular address register into an inclusive byte-address window. It produces a start and an end bound, stores them in a per-entry table and flags which entries hold a computed window. The configuration bytes and address registers are live inputs from the surrounding register file. Whenever one of them is written, the owner pulses an update strobe with the entry index and the kind of write, and the block recomputes that entry's window on the next clock edge.

An entry whose mode is top-of-range takes its lower bound from the address register of the entry below it. Writing an address register can therefore change two windows. After an address write to entry k, if entry k+1 is in top-of-range mode, the block spends one further cycle recomputing entry k+1 and raises `busy` during that cycle. Strobes that arrive while `busy` is high are dropped.

Top module: `prot_range_dec`

## Requirements
- R1: After reset every start and end bound is 0, every bit of `region_vld` is 0 and `busy` is 0.
- R2: The mode is bits [4:3] of the entry's configuration byte, encoded as 0 off, 1 top-of-range, 2 four-byte, 3 power-of-two. In mode 0 the window is start 0, end all ones (width AW+2).
- R3: In mode 1 the start is the previous entry's address register times 4 and the end is this entry's address register times 4, minus 1. Entry 0 uses 0 as its previous address.
- R4: In mode 1, when the computed start exceeds the computed end, both bounds are stored as 0.
- R5: In mode 2 the start is the address register times 4 and the end is the start plus 3.
- R6: In mode 3, with t = (address register times 4) OR 3, the start is t AND (t+1) and the end is t OR (t+1), all in AW+2 bits.
- R7: An accepted strobe with `upd_kind`=1 (address write) to entry k < N_ENT-1, where entry k+1 is in mode 1, updates entry k on the next edge. It then holds `busy` high for exactly one cycle and updates entry k+1 on the edge that ends that cycle.
- R8: A configuration write (`upd_kind`=0), or an address write whose next entry is not in mode 1 or that targets the last entry, updates only the addressed entry and leaves `busy` low.
- R9: A strobe presented while `busy` is high is ignored: no entry is changed by it.
- R10: `region_vld[i]` is set by the first update of entry i and stays set until reset.
- R11: For every entry with `region_vld` set, the end bound is never below the start bound.
- R12: Without an accepted strobe or a pending follow-up, the stored bounds do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | Update strobe, one cycle per write |
| upd_kind | input | 1 | 1 = address register write, 0 = configuration write |
| upd_idx | input | IW | Index of the written entry |
| cfg_bytes | input | N_ENT*8 | Configuration bytes, entry i at bits [8i+7:8i] |
| addr_regs | input | N_ENT*AW | Address registers, entry i at bits [AW*i+AW-1:AW*i] |
| region_start | output | N_ENT*(AW+2) | Start byte address per entry |
| region_end | output | N_ENT*(AW+2) | Inclusive end byte address per entry |
| region_vld | output | N_ENT | Entry has been computed since reset |
| busy | output | 1 | Dependent next entry is being recomputed |

## Verification
Each of the four modes is driven with addresses that separate the decodings. A power-of-two address with trailing ones yields a window size that only the trailing-ones rule gives. The all-ones and all-zeros power-of-two cases expose carry handling at the width edges. A four-byte window at the same address as a top-of-range window distinguishes the two bound formulas. Top-of-range is tried at entry 0, which has an implied zero base, with an ordinary ascending pair and with an inverted pair that must collapse to zero. The cascade is exercised with address writes that do and do not trigger the extra cycle, namely a next entry that is or is not top-of-range and the last entry, and with a configuration write beside a top-of-range neighbour. A strobe during `busy` aimed at a different entry shows whether it leaks through.

// File: rtl/prot_range_dec.sv
module prot_range_dec #(
  parameter int N_ENT = 8,
  parameter int AW    = 16,
  parameter int IW    = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  upd_valid,
  input  logic                  upd_kind,
  input  logic [IW-1:0]         upd_idx,
  input  logic [N_ENT*8-1:0]    cfg_bytes,
  input  logic [N_ENT*AW-1:0]   addr_regs,
  output logic [N_ENT*(AW+2)-1:0] region_start,
  output logic [N_ENT*(AW+2)-1:0] region_end,
  output logic [N_ENT-1:0]      region_vld,
  output logic                  busy
);
  localparam int BW = AW + 2;
  localparam logic [1:0] M_OFF = 2'd0, M_TOR = 2'd1, M_NA4 = 2'd2, M_NAPOT = 2'd3;

  logic [1:0]    mode_a [N_ENT];
  logic [AW-1:0] addr_a [N_ENT];
  logic [AW-1:0] prev_a [N_ENT];
  logic [BW-1:0] st_q [N_ENT];
  logic [BW-1:0] en_q [N_ENT];
  logic [N_ENT-1:0] vld_q;
  logic          busy_q;
  logic [IW-1:0] pend_q;

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    assign mode_a[g] = cfg_bytes[g*8+3 +: 2];
    assign addr_a[g] = addr_regs[g*AW +: AW];
    if (g == 0) begin : g_first
      assign prev_a[g] = '0;
    end else begin : g_rest
      assign prev_a[g] = addr_regs[(g-1)*AW +: AW];
    end
    assign region_start[g*BW +: BW] = st_q[g];
    assign region_end[g*BW +: BW]   = en_q[g];
  end

  wire           idx_ok = int'(upd_idx) < N_ENT;
  wire           accept = upd_valid && !busy_q && idx_ok;
  wire [IW-1:0]  sel    = busy_q ? pend_q : upd_idx;
  wire           do_wr  = accept || busy_q;
  wire [IW-1:0]  nxt    = upd_idx + IW'(1);
  wire           has_nxt = (int'(upd_idx) + 1) < N_ENT;
  wire           follow = accept && upd_kind && has_nxt && (mode_a[nxt] == M_TOR);

  logic [BW-1:0] a4, p4, t, s, e;

  always_comb begin
    a4 = {addr_a[sel], 2'b00};
    p4 = {prev_a[sel], 2'b00};
    t  = a4 | BW'(3);
    s  = '0;
    e  = '0;
    case (mode_a[sel])
      M_OFF: begin
        s = '0;
        e = '1;
      end
      M_TOR: begin
        s = p4;
        e = a4 - BW'(1);
        if (s > e) begin
          s = '0;
          e = '0;
        end
      end
      M_NA4: begin
        s = a4;
        e = a4 + BW'(3);
      end
      default: begin
        s = t & (t + BW'(1));
        e = t | (t + BW'(1));
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ENT; i++) begin
        st_q[i] <= '0;
        en_q[i] <= '0;
      end
      vld_q  <= '0;
      busy_q <= 1'b0;
      pend_q <= '0;
    end else begin
      if (do_wr) begin
        st_q[sel]  <= s;
        en_q[sel]  <= e;
        vld_q[sel] <= 1'b1;
      end
      busy_q <= follow;
      if (follow) pend_q <= nxt;
    end
  end

  assign region_vld = vld_q;
  assign busy       = busy_q;
endmodule

// File: rtl/prot_range_dec_chk.sv
module prot_range_dec_chk #(
  parameter int N_ENT = 8,
  parameter int AW    = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      upd_valid,
  input logic                      upd_kind,
  input logic [N_ENT*(AW+2)-1:0]   region_start,
  input logic [N_ENT*(AW+2)-1:0]   region_end,
  input logic [N_ENT-1:0]          region_vld,
  input logic                      busy
);
  localparam int BW = AW + 2;

  AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) busy |=> !busy); // R7
  AST_BUSY_FROM_ADDR_WR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(upd_valid && upd_kind)); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_valid && !busy) |=> ($stable(region_start) && $stable(region_end))); // R12

  for (genvar g = 0; g < N_ENT; g++) begin : g_chk
    AST_END_NOT_BELOW_START: assert property (@(posedge clk) disable iff (!rst_n)
      region_vld[g] |-> (region_end[g*BW +: BW] >= region_start[g*BW +: BW])); // R11
    AST_VLD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(region_vld[g])); // R10
  end
endmodule

bind prot_range_dec prot_range_dec_chk #(.N_ENT(N_ENT), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_kind(upd_kind),
  .region_start(region_start), .region_end(region_end),
  .region_vld(region_vld), .busy(busy)
);

// File: tb/prot_range_dec_bench.sv
module prot_range_dec_bench;
  localparam int N  = 8;
  localparam int AW = 16;
  localparam int BW = AW + 2;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic upd_valid = 1'b0;
  logic upd_kind = 1'b0;
  logic [IW-1:0] upd_idx = '0;
  logic [7:0]    cfg_m  [N];
  logic [AW-1:0] addr_m [N];
  logic [N*8-1:0]  cfg_bytes;
  logic [N*AW-1:0] addr_regs;
  logic [N*BW-1:0] region_start, region_end;
  logic [N-1:0] region_vld;
  logic busy;
  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      cfg_bytes[i*8 +: 8]   = cfg_m[i];
      addr_regs[i*AW +: AW] = addr_m[i];
    end
  end

  prot_range_dec #(.N_ENT(N), .AW(AW)) u_prot_range_dec (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_kind(upd_kind),
    .upd_idx(upd_idx), .cfg_bytes(cfg_bytes), .addr_regs(addr_regs),
    .region_start(region_start), .region_end(region_end),
    .region_vld(region_vld), .busy(busy)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp_v);
    n_run++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  task automatic chk_ent(input string req, input int i, input logic [BW-1:0] es, input logic [BW-1:0] ee);
    chk(req, 64'(region_start[i*BW +: BW]), 64'(es));
    chk(req, 64'(region_end[i*BW +: BW]), 64'(ee));
  endtask

  task automatic strobe(input logic kind, input int idx);
    @(negedge clk);
    upd_valid = 1'b1;
    upd_kind  = kind;
    upd_idx   = IW'(idx);
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 start0", 64'(region_start), 64'd0);
    chk("R1 end0", 64'(region_end), 64'd0);
    chk("R1 vld", 64'(region_vld), 64'd0);
    chk("R1 busy", 64'(busy), 64'd0);
  endtask

  task automatic t_off;
    cfg_m[2] = 8'h00; addr_m[2] = 16'h1234;
    strobe(1'b0, 2);
    chk_ent("R2 off", 2, 18'h0, 18'h3FFFF);
    chk("R10 vld2", 64'(region_vld[2]), 64'd1);
  endtask

  task automatic t_na4;
    cfg_m[3] = 8'h10; addr_m[3] = 16'h0100;
    strobe(1'b0, 3);
    chk_ent("R5 na4", 3, 18'h400, 18'h403);
  endtask

  task automatic t_napot;
    cfg_m[4] = 8'h18; addr_m[4] = 16'hFFFF;
    strobe(1'b0, 4);
    chk_ent("R6 napot all ones", 4, 18'h0, 18'h3FFFF);
    addr_m[4] = 16'h0000;
    strobe(1'b1, 4);
    chk_ent("R6 napot 8 byte", 4, 18'h0, 18'h7);
    addr_m[4] = 16'h0041;
    strobe(1'b1, 4);
    chk_ent("R6 napot trailing ones", 4, 18'h100, 18'h10F);
    chk("R8 no busy", 64'(busy), 64'd0);
  endtask

  task automatic t_tor;
    cfg_m[0] = 8'h08; addr_m[0] = 16'h0010;
    strobe(1'b0, 0);
    chk_ent("R3 tor entry0", 0, 18'h0, 18'h3F);
    cfg_m[5] = 8'h08; addr_m[5] = 16'h0080;
    strobe(1'b0, 5);
    chk_ent("R3 tor prev", 5, 18'h104, 18'h1FF);
    addr_m[5] = 16'h0020;
    strobe(1'b1, 5);
    chk_ent("R4 tor inverted", 5, 18'h0, 18'h0);
    addr_m[5] = 16'h0080;
    strobe(1'b1, 5);
    chk_ent("R3 tor restore", 5, 18'h104, 18'h1FF);
  endtask

  task automatic t_cascade;
    cfg_m[2] = 8'h10; addr_m[2] = 16'h0200;
    strobe(1'b0, 2);
    chk_ent("R5 na4 entry2", 2, 18'h800, 18'h803);
    addr_m[2] = 16'h0300;
    addr_m[4] = 16'h0030;
    @(negedge clk);
    upd_valid = 1'b1; upd_kind = 1'b1; upd_idx = 3'd4;
    @(negedge clk);
    upd_kind = 1'b0; upd_idx = 3'd2;
    chk("R7 busy high", 64'(busy), 64'd1);
    chk_ent("R7 entry k first", 4, 18'h0C0, 18'h0C7);
    chk_ent("R7 k+1 not yet", 5, 18'h104, 18'h1FF);
    @(negedge clk);
    upd_valid = 1'b0;
    chk("R7 busy low", 64'(busy), 64'd0);
    chk_ent("R7 k+1 updated", 5, 18'h0C0, 18'h1FF);
    chk_ent("R9 ignored during busy", 2, 18'h800, 18'h803);
    addr_m[4] = 16'h0041;
    strobe(1'b0, 4);
    chk("R8 cfg write no busy", 64'(busy), 64'd0);
    @(negedge clk);
    chk_ent("R8 k+1 untouched", 5, 18'h0C0, 18'h1FF);
    cfg_m[7] = 8'h08; addr_m[7] = 16'h0100; addr_m[6] = 16'h0050;
    strobe(1'b1, 7);
    chk("R8 last entry no busy", 64'(busy), 64'd0);
    chk_ent("R3 last", 7, 18'h140, 18'h3FF);
    chk("R10 vld set", 64'(region_vld), 64'hBD);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      cfg_m[i] = 8'h00;
      addr_m[i] = '0;
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_off();
    t_na4();
    t_napot();
    t_tor();
    t_cascade();
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule